// File: doc/BRIEF.md
# Edge-Resynchronized Pulse Train Multiplier

This block turns a slow, externally timed pulse into a fast square wave that runs a fixed number of times faster. It runs entirely off a fast reference clock. A period counter divides that clock down to the output rate. Every rising edge of the slow input, once brought into the clock domain, forces that counter back to the start of a period. As a result, each group of output periods is phase-aligned to the slow input, whatever drift the reference clock may have.

A second counter times the high part of every output period from a duty setting given in reference-clock cycles. The setting is held between one tenth and one half of the period length. With a 1 MHz reference and a period count of 10,000, a 1 Hz input yields a 100 Hz output. A build-time option replaces the terminal-count compare with a plain binary counter that wraps at a power of two, for example 14 bits with a 1.6384 MHz reference.

Between input edges the divider runs freely, so any frequency error builds up until the next edge. That edge then shortens or lengthens one output period. The output stays low from reset until the first input edge has been seen.

Top module: `pulse_mult`

## Requirements
- R1: A rising edge of `slowIn` that is first sampled high at clock edge k, after being sampled low at edge k-1, makes `pulseOut` high after clock edge k+2.
- R2: After reset, `pulseOut` stays low until the first rising edge of `slowIn` takes effect.
- R3: Once started, with no further input edges, `pulseOut` rises every PERIOD_CNT clock cycles when BINARY_WRAP=0.
- R4: A rising edge of `slowIn` in the middle of a period restarts the period: `pulseOut` goes high in the cycle given by R1, cutting the running period short.
- R5: Every period, whether it is started by wrap or by an input edge, begins with `pulseOut` high for exactly the effective duty count of consecutive cycles, and `pulseOut` is then low for the rest of the period.
- R6: A `dutyIn` value below PERIOD/10 (integer division) gives an effective duty count of PERIOD/10.
- R7: A `dutyIn` value above PERIOD/2 (integer division) gives an effective duty count of PERIOD/2.
- R8: Holding `slowIn` high, or letting it fall, has no effect on the output timing. Only rising edges restart the period.
- R9: With BINARY_WRAP=1, the period is 2**DIV_W cycles. The counter wraps through a natural binary overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| slowIn | input | 1 | Asynchronous slow timing pulse, idle low |
| dutyIn | input | DW | Requested high time in clock cycles, clamped to PERIOD/10 .. PERIOD/2 |
| pulseOut | output | 1 | Multiplied square wave, idle low |

## Verification
Two functions can land in the same cycle: an input edge that restarts the period, and the counter's own wrap at the last count of a period. The bench waits for an observed period start and then delays its input edge so that the detected edge meets count PERIOD-1 exactly. It places another edge one count earlier, and several others mid-period. Both a compare-based instance and a binary-wrap instance are judged on every clock against a behavioural model, together with explicit checks of period length and high time.

// File: rtl/pulse_mult_pkg.sv
package pulse_mult_pkg;

  // Strobes handed from the control unit to the datapath
  typedef struct packed {
    logic restart;      // synchronized input rising edge this cycle
    logic periodStart;  // a new output period begins next cycle
    logic running;      // pulse generation enabled
  } pmStrobes_t;

  typedef enum logic [0:0] {
    PM_IDLE = 1'b0,
    PM_RUN  = 1'b1
  } pmState_t;

endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic riseOut
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  // Synchronizer chain: stage 0 takes the asynchronous input
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) syncQ[0] <= 1'b0;
          else     syncQ[0] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) syncQ[i] <= 1'b0;
          else     syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  // Remember the previous synchronized level for edge detection
  always_ff @(posedge clk) begin
    if (rst) prevQ <= 1'b0;
    else     prevQ <= syncQ[TOP];
  end

  assign riseOut = syncQ[TOP] & ~prevQ;

endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pulse_mult_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       riseIn,
  input  logic       wrapIn,
  output pmStrobes_t strobes
);

  pmState_t stateQ;
  pmState_t stateNext;

  // Generation is armed by the first detected edge and stays armed
  always_comb begin
    stateNext = stateQ;
    if (riseIn) stateNext = PM_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= PM_IDLE;
    else     stateQ <= stateNext;
  end

  always_comb begin
    strobes.running     = (stateQ == PM_RUN);
    strobes.restart     = riseIn;
    // An input edge wins over, and coincides harmlessly with, a wrap
    strobes.periodStart = riseIn | ((stateQ == PM_RUN) & wrapIn);
  end

endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pulse_mult_pkg::*;
#(
  parameter int PERIOD_CNT  = 10000,
  parameter bit BINARY_WRAP = 1'b0,
  parameter int DIV_W       = 14,
  localparam int PERIOD_LEN = BINARY_WRAP ? (1 << DIV_W) : PERIOD_CNT,
  localparam int CW         = BINARY_WRAP ? DIV_W : $clog2(PERIOD_CNT),
  localparam int DW         = $clog2(PERIOD_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  pmStrobes_t    strobes,
  input  logic [DW-1:0] dutyIn,
  output logic [CW-1:0] periodCnt,
  output logic          wrapOut,
  output logic          pulseOut
);

  localparam logic [DW-1:0] DUTY_MIN = DW'(PERIOD_LEN / 10);
  localparam logic [DW-1:0] DUTY_MAX = DW'(PERIOD_LEN / 2);
  localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD_LEN - 1);

  logic [CW-1:0] periodNext;
  logic [DW-1:0] dutyEff;
  logic [DW-1:0] highCnt;
  logic          highOn;

  // Period divider variant chosen at build time
  generate
    if (BINARY_WRAP) begin : gBinary
      // Wrap is the all-ones state; the increment overflows to zero itself
      assign wrapOut    = &periodCnt;
      assign periodNext = periodCnt + 1'b1;
    end else begin : gCompare
      assign wrapOut    = (periodCnt == LAST_CNT);
      assign periodNext = wrapOut ? '0 : periodCnt + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                      periodCnt <= '0;
    else if (strobes.periodStart) periodCnt <= '0;
    else if (strobes.running)     periodCnt <= periodNext;
  end

  // Duty clamp into the allowed window
  always_comb begin
    if (dutyIn < DUTY_MIN)      dutyEff = DUTY_MIN;
    else if (dutyIn > DUTY_MAX) dutyEff = DUTY_MAX;
    else                        dutyEff = dutyIn;
  end

  // High-time counter: starts each period high and counts high cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      highOn  <= 1'b0;
      highCnt <= '0;
    end else if (strobes.periodStart) begin
      highOn  <= 1'b1;
      highCnt <= DW'(1);
    end else if (highOn) begin
      if (highCnt >= dutyEff) highOn <= 1'b0;
      else                    highCnt <= highCnt + 1'b1;
    end
  end

  assign pulseOut = highOn;

endmodule

// File: rtl/pulse_mult.sv
module pulse_mult
  import pulse_mult_pkg::*;
#(
  parameter int PERIOD_CNT  = 10000,
  parameter bit BINARY_WRAP = 1'b0,
  parameter int DIV_W       = 14,
  parameter int SYNC_STAGES = 2,
  localparam int PERIOD_LEN = BINARY_WRAP ? (1 << DIV_W) : PERIOD_CNT,
  localparam int CW         = BINARY_WRAP ? DIV_W : $clog2(PERIOD_CNT),
  localparam int DW         = $clog2(PERIOD_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slowIn,
  input  logic [DW-1:0] dutyIn,
  output logic          pulseOut
);

  logic          riseDet;
  logic          wrapDet;
  logic [CW-1:0] periodCnt;
  pmStrobes_t    strobes;

  pm_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) uSync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(slowIn),
    .riseOut(riseDet)
  );

  pm_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .riseIn (riseDet),
    .wrapIn (wrapDet),
    .strobes(strobes)
  );

  pm_datapath #(
    .PERIOD_CNT (PERIOD_CNT),
    .BINARY_WRAP(BINARY_WRAP),
    .DIV_W      (DIV_W)
  ) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dutyIn   (dutyIn),
    .periodCnt(periodCnt),
    .wrapOut  (wrapDet),
    .pulseOut (pulseOut)
  );

endmodule

// File: rtl/pulse_mult_chk.sv
module pulse_mult_chk #(
  parameter int PERIOD_LEN = 10000,
  parameter int CW         = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          riseDet,
  input logic          running,
  input logic [CW-1:0] periodCnt,
  input logic          pulseOut
);

  localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD_LEN - 1);
  localparam int            DMIN     = PERIOD_LEN / 10;
  localparam int            DMAX     = PERIOD_LEN / 2;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !running |-> !pulseOut); // R2

  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (rst)
    riseDet |=> (periodCnt == '0) && pulseOut); // R4

  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (running && !riseDet && periodCnt == LAST_CNT) |=> periodCnt == '0); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    periodCnt <= LAST_CNT); // R3

  AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
    (running && periodCnt == '0) |-> pulseOut); // R5

  AST_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    (running && int'(periodCnt) < DMIN) |-> pulseOut); // R6

  AST_MAX_HIGH: assert property (@(posedge clk) disable iff (rst)
    pulseOut |-> int'(periodCnt) < DMAX); // R7

endmodule

bind pulse_mult pulse_mult_chk #(
  .PERIOD_LEN(PERIOD_LEN),
  .CW        (CW)
) uChk (
  .clk      (clk),
  .rst      (rst),
  .riseDet  (riseDet),
  .running  (strobes.running),
  .periodCnt(periodCnt),
  .pulseOut (pulseOut)
);

// File: tb/sim_pulse_mult.sv
module sim_pulse_mult_ref #(
  parameter int P = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slowIn,
  input  logic [5:0] duty,
  output logic       expOut
);
  bit hist[$];
  int pc, hc, eff;
  bit run, on, rise;

  initial begin
    hist = '{0, 0, 0};
    expOut = 1'b0;
    run = 0; on = 0; pc = 0; hc = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      hist = '{0, 0, 0};
      run = 0; on = 0; pc = 0; hc = 0;
    end else begin
      // input seen two samples ago is high, three samples ago low
      rise = hist[1] && !hist[2];
      eff = int'(duty);
      if (eff < P / 10) eff = P / 10;
      if (eff > P / 2)  eff = P / 2;
      hist.push_front(slowIn);
      void'(hist.pop_back());
      if (rise || (run && pc == P - 1)) begin
        run = 1; pc = 0; on = 1; hc = 1;
      end else if (run) begin
        pc++;
        if (on) begin
          if (hc >= eff) on = 0;
          else hc++;
        end
      end
    end
    expOut = on;
  end
endmodule

module sim_pulse_mult;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slowIn = 1'b0;
  logic [5:0] duty = 6'd10;
  logic       out0, out1, exp0, exp1;
  int         checks = 0;
  int         errors = 0;
  bit         cmpEn = 0;
  string      curReq = "R2";

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Compare-based divider, period 40: duty window 4..20
  pulse_mult #(.PERIOD_CNT(40), .BINARY_WRAP(1'b0)) u0 (
    .clk(clk), .rst(rst), .slowIn(slowIn), .dutyIn(duty), .pulseOut(out0));
  // Binary-wrap divider, 5 bits, period 32: duty window 3..16
  pulse_mult #(.BINARY_WRAP(1'b1), .DIV_W(5)) u1 (
    .clk(clk), .rst(rst), .slowIn(slowIn), .dutyIn(duty), .pulseOut(out1));

  sim_pulse_mult_ref #(.P(40)) ref0 (.clk(clk), .rst(rst), .slowIn(slowIn), .duty(duty), .expOut(exp0));
  sim_pulse_mult_ref #(.P(32)) ref1 (.clk(clk), .rst(rst), .slowIn(slowIn), .duty(duty), .expOut(exp1));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle model comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (cmpEn && !rst) begin
      check({curReq, " u0"}, out0, exp0);
      check({curReq, " u1"}, out1, exp1);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Wait until the selected output has just risen (observed at a negedge)
  task automatic waitRise(input bit sel);
    bit p;
    p = sel ? out1 : out0;
    forever begin
      @(negedge clk);
      if ((sel ? out1 : out0) && !p) break;
      p = sel ? out1 : out0;
    end
  endtask

  task automatic measure(input bit sel, output int width, output int period);
    waitRise(sel);
    width = 0; period = 0;
    while (sel ? out1 : out0) begin
      width++; period++;
      @(negedge clk);
    end
    while (!(sel ? out1 : out0)) begin
      period++;
      @(negedge clk);
    end
  endtask

  task automatic pulseSlow(input int highCycles);
    slowIn = 1'b1;
    cycles(highCycles);
    slowIn = 1'b0;
  endtask

  initial begin
    int w, p;
    cycles(4);
    check("R2 reset u0", out0, 0);
    check("R2 reset u1", out1, 0);
    rst = 1'b0;
    cmpEn = 1;

    // R2: no edge yet, output must stay low
    cycles(100);
    check("R2 idle u0", out0, 0);
    check("R2 idle u1", out1, 0);

    // R1: edge latency
    curReq = "R1";
    slowIn = 1'b1;
    cycles(2);
    check("R1 before u0", out0, 0);
    cycles(1);
    check("R1 after u0", out0, 1);
    check("R1 after u1", out1, 1);

    // R8: held high then falling, output timing unaffected
    curReq = "R8";
    cycles(120);
    slowIn = 1'b0;
    cycles(90);

    // R3 / R5 / R9: free-running periods and high time
    curReq = "R3";
    measure(1'b0, w, p);
    check("R3 period u0", p, 40);
    check("R5 width u0", w, 10);
    curReq = "R9";
    measure(1'b1, w, p);
    check("R9 period u1", p, 32);
    check("R5 width u1", w, 10);

    // R6: low clamp
    curReq = "R6";
    duty = 6'd1;
    cycles(45);
    measure(1'b0, w, p);
    check("R6 clamp u0", w, 4);
    measure(1'b1, w, p);
    check("R6 clamp u1", w, 3);

    // R7: high clamp
    curReq = "R7";
    duty = 6'd63;
    cycles(45);
    measure(1'b0, w, p);
    check("R7 clamp u0", w, 20);
    check("R7 period u0", p, 40);
    measure(1'b1, w, p);
    check("R7 clamp u1", w, 16);

    // R4: mid-period restart at count 17 of u0
    curReq = "R4";
    duty = 6'd10;
    cycles(45);
    waitRise(1'b0);
    cycles(15);
    slowIn = 1'b1;
    cycles(2);
    check("R4 before u0", out0, 0);
    cycles(1);
    check("R4 restart u0", out0, 1);
    check("R4 restart u1", out1, 1);
    cycles(5);
    slowIn = 1'b0;
    measure(1'b0, w, p);
    check("R4 next period u0", p, 40);

    // Edge detected at count 38: one period cut by a single cycle
    waitRise(1'b0);
    cycles(36);
    pulseSlow(6);
    cycles(60);

    // Edge detected exactly at the wrap count 39
    waitRise(1'b0);
    cycles(37);
    slowIn = 1'b1;
    cycles(3);
    check("R4 wrap coincide u0", out0, 1);
    cycles(3);
    slowIn = 1'b0;
    measure(1'b0, w, p);
    check("R3 after coincide u0", p, 40);

    // Several edges at spread phases
    for (int k = 0; k < 6; k++) begin
      cycles(7 + k * 11);
      pulseSlow(4 + k);
    end
    cycles(100);

    cmpEn = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule